// File: doc/BRIEF.md
# Overhead-Aware Serial Payload Feeder

The feeder sits on the system side of a framer's transmit payload input, where the payload lane runs on a continuous clock. It takes bytes from an upstream valid/ready port and hands them to the framer one bit at a time, or four bits at a time in nibble mode. The framer raises an overhead indicator whenever it is inserting its own overhead and cannot take payload.

The feeder samples that indicator on the falling edge of the active bit clock. It uses the sample to decide on the next rising edge whether to present a new payload unit or to hold the current one.

A select input chooses the bit clock: either the transmit input clock or the recovered receive output clock. If no byte is on hand when the framer opens a payload slot, the feeder sends an all-ones idle unit and latches an underrun flag.

Top module: `ovh_payload_feeder`

## Requirements
- R1: The overhead indicator is sampled on the falling edge of the active bit clock. Only that sample governs the following rising edge.
- R2: When the falling-edge sample is low and a payload unit is available, the next unit appears on `tx_dat` at the following rising edge. No unit is lost or repeated.
- R3: When the falling-edge sample is high, `tx_dat` and the position within the current byte stay unchanged across the following rising edge.
- R4: With `clk_sel` low, the block runs on `clk_tx`. With `clk_sel` high, it runs on `clk_rx`. R1 to R3 apply unchanged on either clock.
- R5: In serial mode (`nib_mode` low), a unit is one bit on `tx_dat[0]` and `tx_dat[3:1]` stay at 3'b111. In nibble mode (`nib_mode` high), a unit is four bits on `tx_dat[3:0]`. Both modes follow the same stall rule.
- R6: Bytes leave most significant bit first. In nibble mode, bits 7:4 leave before bits 3:0.
- R7: `in_ready` is high exactly when the previous byte has been fully handed out. A byte is taken on a rising edge with `in_valid` and `in_ready` both high. If that edge is an open slot, the byte's first unit leaves on that same edge. After any taken byte, `in_ready` is low in the next cycle.
- R8: When a slot opens with no byte on hand, `tx_dat` becomes 4'hF and `underrun` rises. `underrun` then stays high until reset.
- R9: While `rst_n` is low, `tx_dat` is 4'hF, `underrun` is 0, `in_ready` is 1 and the falling-edge sample is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Transmit input bit clock |
| clk_rx | input | 1 | Recovered receive output bit clock |
| clk_sel | input | 1 | Bit clock select, 1 picks clk_rx (static) |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_mode | input | 1 | 1 for nibble transfers, 0 for serial (static) |
| ovh_ind | input | 1 | Overhead indicator from the framer |
| in_data | input | 8 | Upstream payload byte |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Feeder can take a byte |
| tx_dat | output | 4 | Payload unit to the framer |
| underrun | output | 1 | Sticky idle-insertion flag |

## Verification
The indicator value present at a falling edge decides the very next rising edge. A unit or an idle fill is therefore due on `tx_dat` in the same cycle as that rising edge, and the bench reads it 1 ns after the edge. The bench keeps its own falling-edge copy of the indicator, and a scoreboard queue is filled at each handshake edge. On every open slot the monitor pops the next expected unit, and on every closed slot it requires the previous value. `in_ready` and `underrun` are due on the accepting or idle edge itself and are read at the same 1 ns offset.

// File: rtl/ovh_payload_feeder.sv
module ovh_payload_feeder #(
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk_tx,
  input  logic          clk_rx,
  input  logic          clk_sel,
  input  logic          rst_n,
  input  logic          nib_mode,
  input  logic          ovh_ind,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [LW-1:0] tx_dat,
  output logic          underrun
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] N_SER = CW'(DW);
  localparam logic [CW-1:0] N_NIB = CW'(DW / LW);

  logic bclk;
  assign bclk = clk_sel ? clk_rx : clk_tx;

  logic ovh_q;
  always_ff @(negedge bclk or negedge rst_n)
    if (!rst_n) ovh_q <= 1'b0;
    else        ovh_q <= ovh_ind;

  logic [DW-1:0] sreg;
  logic [CW-1:0] cnt;
  logic [LW-1:0] dat_q;
  logic          urun_q;

  logic          take;
  logic [DW-1:0] src;
  logic [LW-1:0] unit;
  logic [DW-1:0] nxt;
  logic [CW-1:0] units;

  assign in_ready = (cnt == '0);
  assign take     = in_valid && in_ready;
  assign src      = take ? in_data : sreg;
  assign unit     = nib_mode ? src[DW-1 -: LW] : {{(LW-1){1'b1}}, src[DW-1]};
  assign nxt      = nib_mode ? (src << LW) : (src << 1);
  assign units    = nib_mode ? N_NIB : N_SER;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      cnt    <= '0;
      dat_q  <= '1;
      urun_q <= 1'b0;
    end else if (!ovh_q) begin
      if (take) begin
        dat_q <= unit;
        sreg  <= nxt;
        cnt   <= units - 1'b1;
      end else if (cnt != '0) begin
        dat_q <= unit;
        sreg  <= nxt;
        cnt   <= cnt - 1'b1;
      end else begin
        dat_q  <= '1;
        urun_q <= 1'b1;
      end
    end else if (take) begin
      sreg <= in_data;
      cnt  <= units;
    end
  end

  assign tx_dat   = dat_q;
  assign underrun = urun_q;

  AST_STALL_HOLDS_DATA: assert property (@(posedge bclk) disable iff (!rst_n)
    ovh_q |=> $stable(tx_dat)); // R3
  AST_STALL_HOLDS_PTR: assert property (@(posedge bclk) disable iff (!rst_n)
    (ovh_q && !take) |=> $stable(cnt)); // R3
  AST_SLOT_ADVANCES: assert property (@(posedge bclk) disable iff (!rst_n)
    (!ovh_q && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_TAKE_DROPS_READY: assert property (@(posedge bclk) disable iff (!rst_n)
    take |=> !in_ready); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
    underrun |=> underrun); // R8
  AST_UNDERRUN_IDLE: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(underrun) |-> (tx_dat == '1)); // R8
  AST_SERIAL_UPPER_IDLE: assert property (@(posedge bclk) disable iff (!rst_n)
    !nib_mode |-> (&tx_dat[LW-1:1])); // R5
endmodule

// File: tb/ovh_payload_feeder_bench.sv
module ovh_payload_feeder_bench;
  logic clk_tx = 0, clk_rx = 0, clk_sel = 0, rst_n = 0, nib_mode = 0;
  logic ovh_ind = 0, in_valid = 0;
  logic [7:0] in_data = '0;
  logic in_ready, underrun;
  logic [3:0] tx_dat;

  ovh_payload_feeder u_ovh_payload_feeder (
    .clk_tx(clk_tx), .clk_rx(clk_rx), .clk_sel(clk_sel), .rst_n(rst_n),
    .nib_mode(nib_mode), .ovh_ind(ovh_ind), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .tx_dat(tx_dat),
    .underrun(underrun));

  always #2 clk_tx = ~clk_tx;
  initial begin #1; forever #2 clk_rx = ~clk_rx; end

  logic bclk_b;
  assign bclk_b = clk_sel ? clk_rx : clk_tx;

  int total = 0, bad = 0;
  logic [15:0] pat = '0;
  int ph = 0;
  logic ovh_s = 0, mon_on = 0;
  logic [3:0] last = 4'hF;
  logic [3:0] expq[$];
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge bclk_b); #1;
    ovh_ind = pat[ph];
    ph = (ph + 1) % 16;
  end

  initial forever begin
    @(negedge bclk_b);
    ovh_s = rst_n ? ovh_ind : 1'b0;
  end

  initial forever begin
    @(posedge bclk_b); #1;
    if (mon_on && rst_n) begin
      if (!ovh_s) begin
        logic [3:0] e;
        e = (expq.size() > 0) ? expq.pop_front() : 4'hF;
        chk(tx_dat == e, "R1 R2 R4 R5 R6", "unit", tx_dat, e);
      end else begin
        chk(tx_dat == last, "R3", "held unit", tx_dat, last);
      end
      last = tx_dat;
    end
  end

  task automatic send_byte(logic [7:0] b);
    in_data = b;
    in_valid = 1;
    do @(negedge bclk_b); while (!in_ready);
    @(posedge bclk_b);
    if (nib_mode) begin
      expq.push_back(b[7:4]);
      expq.push_back(b[3:0]);
    end else begin
      for (int i = 7; i >= 0; i--) expq.push_back({3'b111, b[i]});
    end
    #1;
    chk(in_ready == 0, "R7", "ready after take", in_ready, 0);
  endtask

  task automatic run_pass(bit sel, bit nib, logic [15:0] p, int seed);
    mon_on = 0;
    rst_n = 0;
    in_valid = 0;
    clk_sel = sel;
    nib_mode = nib;
    pat = p;
    repeat (3) @(posedge clk_tx);
    #1;
    chk(tx_dat == 4'hF, "R9", "reset tx_dat", tx_dat, 4'hF);
    chk(underrun == 0, "R9", "reset underrun", underrun, 0);
    chk(in_ready == 1, "R9", "reset ready", in_ready, 1);
    in_valid = 1;
    @(posedge bclk_b); #1;
    last = 4'hF;
    rst_n = 1;
    mon_on = 1;
    for (int i = 0; i < 24; i++) send_byte(8'(i * 37 + seed));
    chk(underrun == 0, "R8", "no underrun while fed", underrun, 0);
    in_valid = 0;
    repeat (40) @(posedge bclk_b);
    #1;
    chk(underrun == 1, "R8", "underrun when starved", underrun, 1);
    chk(tx_dat == 4'hF, "R8", "idle fill", tx_dat, 4'hF);
    chk(expq.size() == 0, "R2", "units left in scoreboard", expq.size(), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run_pass(0, 0, 16'b0000_0110_0000_0001, 8'h5A);
    run_pass(1, 1, 16'b0011_0000_1000_0100, 8'hC3);
    run_pass(0, 1, 16'b0000_0000_0000_0000, 8'h0F);
    run_pass(1, 0, 16'b1110_0001_0010_1100, 8'hA5);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule